// File: doc/BRIEF.md
# Test Pattern Frame Generator

This block feeds the 256-bit transmit side of a network core with synthetic payload frames for link testing. Every beat carries a composite test word: a beat counter (ramp A), a frame counter (ramp B) and a single set bit that rotates across a 128-bit field. The receiver can check ordering, frame boundaries and bit integrity from this word alone. A frame is a run of valid beats with end-of-frame marked on its last beat. The destination address and port travel alongside the frame and stay fixed for its whole length.

Frames are produced only while both enables in a 6-bit control word are high. A programmable gap separates consecutive frames. The gap exists because the user clock runs faster than the core clock, and without it the core's crossing buffers would fill. The core's almost-full flag stalls the block beat by beat. A packet reset aborts the current frame and restarts all three pattern fields.

The sequencer has three states. SEND_IDLE waits for both enables and then moves to SEND_BEATS. SEND_BEATS issues beats. On its last accepted beat it goes to SEND_GAP when the gap setting is non-zero, and to SEND_IDLE when it is zero. SEND_GAP counts down and then returns to SEND_IDLE. A packet reset forces SEND_IDLE from any state.

Top module: `tpat_frame_gen`

## Requirements
- R1: Each beat of `tx_data` is laid out as ramp A in bits [255:192], ramp B in bits [191:128] and the rotating one-hot field in bits [127:0].
- R2: Ramp A starts at 0 and rises by one after every accepted beat, across frame boundaries, wrapping modulo 2^64.
- R3: Ramp B starts at 0, stays constant within a frame and rises by one after each end-of-frame beat.
- R4: The one-hot field starts with bit 0 set and moves one place toward the MSB after every accepted beat, with bit 127 wrapping to bit 0.
- R5: A frame carries exactly L beats, and `tx_eof` is high only with `tx_valid` on the L-th beat. L is `frame_len` sampled at frame start, with 0 treated as 1 and any value above 256 treated as 256.
- R6: With both enables held high and almost-full low, exactly `decim`+1 cycles with `tx_valid` low separate an end-of-frame beat from the next frame's first beat.
- R7: A frame starts only when control bit 3 (transmit enable) and bit 4 (packet enable) are both high. Once started, a frame runs to its last beat even if either enable drops.
- R8: While `core_afull` is high, `tx_valid` is low and all pattern fields and the beat position are held. The frame then resumes with the next unsent beat.
- R9: While control bit 2 (packet reset) is high, `tx_valid` is low and the current frame is abandoned. After release, the next beat carries ramp A = 0, ramp B = 0 and bit 0 of the one-hot field.
- R10: `tx_dst_ip` and `tx_dst_port` take the configuration values at frame start and remain unchanged until that frame's end-of-frame beat.
- R11: `core_rst`, `dbg_rst` and `cap_arm` follow control bits 0, 1 and 5 combinationally.
- R12: After `rst_n` is released, `tx_valid` and `tx_eof` are low and `tx_data` reads ramp A = 0, ramp B = 0 and one-hot bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 6 | Control bits: 0 core reset, 1 debug reset, 2 packet reset, 3 transmit enable, 4 packet enable, 5 capture arm |
| frame_len | input | 9 | Beats per frame, sampled at frame start |
| decim | input | 16 | Gap setting, sampled on the end-of-frame beat |
| cfg_dst_ip | input | 32 | Destination IP address configuration |
| cfg_dst_port | input | 16 | Destination UDP port configuration |
| core_afull | input | 1 | Almost-full flag from the core |
| tx_data | output | 256 | Payload beat |
| tx_valid | output | 1 | Beat is presented this cycle |
| tx_eof | output | 1 | Last beat of the frame |
| tx_dst_ip | output | 32 | Destination IP address of the current frame |
| tx_dst_port | output | 16 | Destination port of the current frame |
| core_rst | output | 1 | Core reset request (control bit 0) |
| dbg_rst | output | 1 | Debug logic reset request (control bit 1) |
| cap_arm | output | 1 | Capture arm request (control bit 5) |

## Verification
The assertions assume that `core_afull` and packet reset may change on any cycle. They also assume that `frame_len` and `decim` matter only at the cycles where the sequencer samples them. Because of this, the stall, abort and hold properties are written against these inputs directly, not against a quiet interface. The stimulus changes length and gap only while a packet reset holds the sequencer idle. It changes the destination configuration mid-frame only in the test aimed at R10. It drives almost-full in a fixed periodic pattern during one table row, so the pattern must stay continuous across stalls that hit both the middle and the first beat of a frame.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

    typedef enum logic [1:0] {
        SEND_IDLE  = 2'd0,
        SEND_BEATS = 2'd1,
        SEND_GAP   = 2'd2
    } send_state_e;

    localparam int CB_CORE_RST = 0;
    localparam int CB_DBG_RST  = 1;
    localparam int CB_PKT_RST  = 2;
    localparam int CB_TX_EN    = 3;
    localparam int CB_PKT_EN   = 4;
    localparam int CB_ARM      = 5;
    localparam int CTRL_W      = 6;

endpackage

// File: rtl/tpat_pattern.sv
module tpat_pattern #(
    parameter int RAMP_W = 64,
    parameter int WALK_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic              frame_end,
    output logic [RAMP_W-1:0] ramp_a,
    output logic [RAMP_W-1:0] ramp_b,
    output logic [WALK_W-1:0] walk
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_a <= '0;
            ramp_b <= '0;
            walk   <= WALK_W'(1);
        end else if (clr) begin
            ramp_a <= '0;
            ramp_b <= '0;
            walk   <= WALK_W'(1);
        end else if (adv) begin
            ramp_a <= ramp_a + RAMP_W'(1);
            walk   <= {walk[WALK_W-2:0], walk[WALK_W-1]};
            if (frame_end) begin
                ramp_b <= ramp_b + RAMP_W'(1);
            end
        end
    end

    p_walk_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(walk));

    p_walk_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && walk[WALK_W-1]) |=> walk[0]);

    p_ramp_a_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (ramp_a == $past(ramp_a) + RAMP_W'(1)));

    p_ramp_b_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(adv && frame_end)) |=> $stable(ramp_b));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> ($stable(ramp_a) && $stable(walk)));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ramp_a == '0 && ramp_b == '0 && walk == WALK_W'(1)));

endmodule

// File: rtl/tpat_seq.sv
module tpat_seq
    import tpat_pkg::*;
#(
    parameter int MAX_BEATS = 256,
    parameter int DEC_W     = 16,
    parameter int IP_W      = 32,
    parameter int PORT_W    = 16,
    localparam int LEN_W    = $clog2(MAX_BEATS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              go,
    input  logic              afull,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [DEC_W-1:0]  decim,
    input  logic [IP_W-1:0]   ip_in,
    input  logic [PORT_W-1:0] port_in,
    output logic              tx_valid,
    output logic              tx_eof,
    output logic [IP_W-1:0]   ip_out,
    output logic [PORT_W-1:0] port_out
);

    send_state_e       state_q, state_d;
    logic [LEN_W-1:0]  beat_q;
    logic [LEN_W-1:0]  len_q;
    logic [DEC_W-1:0]  gap_q;
    logic [IP_W-1:0]   ip_q;
    logic [PORT_W-1:0] port_q;
    logic              last_beat;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        if (l == '0) begin
            return LEN_W'(1);
        end else if (l > LEN_W'(MAX_BEATS)) begin
            return LEN_W'(MAX_BEATS);
        end else begin
            return l;
        end
    endfunction

    assign last_beat = (beat_q == len_q - LEN_W'(1));
    assign ip_out    = ip_q;
    assign port_out  = port_q;

    // Output process
    always_comb begin
        tx_valid = (state_q == SEND_BEATS) && !afull && !clr;
        tx_eof   = tx_valid && last_beat;
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEND_IDLE:  if (go) state_d = SEND_BEATS;
            SEND_BEATS: if (tx_eof) state_d = (decim == '0) ? SEND_IDLE : SEND_GAP;
            SEND_GAP:   if (gap_q == '0) state_d = SEND_IDLE;
            default:    state_d = SEND_IDLE;
        endcase
        if (clr) state_d = SEND_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEND_IDLE;
        else        state_q <= state_d;
    end

    // Frame counters and per-frame configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            len_q  <= LEN_W'(1);
            gap_q  <= '0;
            ip_q   <= '0;
            port_q <= '0;
        end else if (clr) begin
            beat_q <= '0;
        end else begin
            unique case (state_q)
                SEND_IDLE: begin
                    if (go) begin
                        beat_q <= '0;
                        len_q  <= clamp_len(frame_len);
                        ip_q   <= ip_in;
                        port_q <= port_in;
                    end
                end
                SEND_BEATS: begin
                    if (tx_valid) begin
                        if (last_beat) begin
                            beat_q <= '0;
                            gap_q  <= decim - DEC_W'(1);
                        end else begin
                            beat_q <= beat_q + LEN_W'(1);
                        end
                    end
                end
                SEND_GAP: gap_q <= gap_q - DEC_W'(1);
                default: ;
            endcase
        end
    end

    p_eof_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eof |-> tx_valid);

    p_beat_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEND_BEATS) |-> (beat_q < len_q && len_q <= LEN_W'(MAX_BEATS)));

    p_gap_after_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eof |=> !tx_valid);

    p_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEND_IDLE && !go) |=> !tx_valid);

    p_afull_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        afull |-> !tx_valid);

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == SEND_IDLE));

    p_dest_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_eof) |=> ($stable(ip_out) && $stable(port_out)));

endmodule

// File: rtl/tpat_frame_gen.sv
module tpat_frame_gen
    import tpat_pkg::*;
#(
    parameter int RAMP_W    = 64,
    parameter int WALK_W    = 128,
    parameter int MAX_BEATS = 256,
    parameter int DEC_W     = 16,
    parameter int IP_W      = 32,
    parameter int PORT_W    = 16,
    localparam int LEN_W    = $clog2(MAX_BEATS) + 1,
    localparam int DATA_W   = 2 * RAMP_W + WALK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [DEC_W-1:0]  decim,
    input  logic [IP_W-1:0]   cfg_dst_ip,
    input  logic [PORT_W-1:0] cfg_dst_port,
    input  logic              core_afull,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    output logic              tx_eof,
    output logic [IP_W-1:0]   tx_dst_ip,
    output logic [PORT_W-1:0] tx_dst_port,
    output logic              core_rst,
    output logic              dbg_rst,
    output logic              cap_arm
);

    logic              pkt_rst;
    logic              go;
    logic [RAMP_W-1:0] ramp_a;
    logic [RAMP_W-1:0] ramp_b;
    logic [WALK_W-1:0] walk;

    assign core_rst = ctrl_word[CB_CORE_RST];
    assign dbg_rst  = ctrl_word[CB_DBG_RST];
    assign cap_arm  = ctrl_word[CB_ARM];
    assign pkt_rst  = ctrl_word[CB_PKT_RST];
    assign go       = ctrl_word[CB_TX_EN] & ctrl_word[CB_PKT_EN];

    tpat_seq #(
        .MAX_BEATS (MAX_BEATS),
        .DEC_W     (DEC_W),
        .IP_W      (IP_W),
        .PORT_W    (PORT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pkt_rst),
        .go        (go),
        .afull     (core_afull),
        .frame_len (frame_len),
        .decim     (decim),
        .ip_in     (cfg_dst_ip),
        .port_in   (cfg_dst_port),
        .tx_valid  (tx_valid),
        .tx_eof    (tx_eof),
        .ip_out    (tx_dst_ip),
        .port_out  (tx_dst_port)
    );

    tpat_pattern #(
        .RAMP_W (RAMP_W),
        .WALK_W (WALK_W)
    ) u_pattern (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pkt_rst),
        .adv       (tx_valid),
        .frame_end (tx_eof),
        .ramp_a    (ramp_a),
        .ramp_b    (ramp_b),
        .walk      (walk)
    );

    assign tx_data = {ramp_a, ramp_b, walk};

    p_ctrl_decode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst == ctrl_word[0] && dbg_rst == ctrl_word[1] && cap_arm == ctrl_word[5]));

endmodule

// File: tb/tpat_frame_gen_tb.sv
`timescale 1ns/1ps
module tpat_frame_gen_tb;

    localparam int ROWS = 6;
    // len, expected len, decim, frames, stall period (0 = none)
    localparam int TBL [ROWS][5] = '{
        '{4,   4,   0, 3, 0},
        '{1,   1,   3, 3, 0},
        '{256, 256, 2, 2, 0},
        '{7,   7,   1, 3, 3},
        '{0,   1,   2, 3, 0},
        '{300, 256, 0, 2, 0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         crst = 0, drst = 0, prst = 0, ten = 0, pen = 0, arm = 0;
    logic [5:0]   ctrl_word;
    logic [8:0]   frame_len = 9'd4;
    logic [15:0]  decim = '0;
    logic [31:0]  cfg_dst_ip = 32'h0A00_0001;
    logic [15:0]  cfg_dst_port = 16'h1234;
    logic         core_afull = 1'b0;
    logic [255:0] tx_data;
    logic         tx_valid, tx_eof;
    logic [31:0]  tx_dst_ip;
    logic [15:0]  tx_dst_port;
    logic         core_rst, dbg_rst, cap_arm;

    assign ctrl_word = {arm, pen, ten, prst, drst, crst};

    always #2 clk = ~clk;

    tpat_frame_gen u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .frame_len(frame_len),
        .decim(decim), .cfg_dst_ip(cfg_dst_ip), .cfg_dst_port(cfg_dst_port),
        .core_afull(core_afull), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_eof(tx_eof), .tx_dst_ip(tx_dst_ip), .tx_dst_port(tx_dst_port),
        .core_rst(core_rst), .dbg_rst(dbg_rst), .cap_arm(cap_arm)
    );

    int n_chk = 0, n_fail = 0;
    logic [63:0]  ea, eb;
    logic [127:0] ew;
    int  bidx, exp_len, exp_gap, frames_seen, gap_n;
    bit  gap_armed, gap_chk;

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        ea = '0; eb = '0; ew = 128'd1; bidx = 0; frames_seen = 0;
        gap_armed = 0; gap_n = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic observe();
        bit last;
        if (core_afull) chk(!tx_valid, "R8 valid during almost-full", 256'(tx_valid), 256'd0);
        if (tx_valid) begin
            last = (bidx == exp_len - 1);
            chk(tx_data[255:192] == ea, "R1,R2 ramp A field", 256'(tx_data[255:192]), 256'(ea));
            chk(tx_data[191:128] == eb, "R1,R3 ramp B field", 256'(tx_data[191:128]), 256'(eb));
            chk(tx_data[127:0] == ew, "R1,R4 one-hot field", 256'(tx_data[127:0]), 256'(ew));
            chk(tx_eof == last, "R5 end-of-frame position", 256'(tx_eof), 256'(last));
            if (gap_armed && gap_chk)
                chk(gap_n == exp_gap, "R6 inter-frame gap", 256'(gap_n), 256'(exp_gap));
            gap_armed = 0;
            ea = ea + 64'd1;
            ew = {ew[126:0], ew[127]};
            if (last) begin
                eb = eb + 64'd1; bidx = 0; frames_seen++;
                gap_armed = 1; gap_n = 0;
            end else begin
                bidx++;
            end
        end else if (gap_armed) begin
            gap_n++;
        end
    endtask

    task automatic pkt_reset(input bit t, input bit p);
        tick();
        prst = 1; ten = t; pen = p; core_afull = 0;
        #1;
        chk(!tx_valid, "R9 valid low during packet reset", 256'(tx_valid), 256'd0);
        tick();
        prst = 0;
        model_reset();
    endtask

    bit done = 0;

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int nv;
        bit first;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick(); #1;
        // R12: state right after reset
        chk(!tx_valid, "R12 valid after reset", 256'(tx_valid), 256'd0);
        chk(!tx_eof, "R12 eof after reset", 256'(tx_eof), 256'd0);
        chk(tx_data == {64'd0, 64'd0, 128'd1}, "R12 data after reset", tx_data, {64'd0, 64'd0, 128'd1});

        // R11: control decode
        crst = 1; drst = 1; arm = 1; #1;
        chk({core_rst, dbg_rst, cap_arm} == 3'b111, "R11 decode all set", 256'({core_rst, dbg_rst, cap_arm}), 256'd7);
        crst = 0; drst = 1; arm = 0; #1;
        chk({core_rst, dbg_rst, cap_arm} == 3'b010, "R11 decode debug only", 256'({core_rst, dbg_rst, cap_arm}), 256'd2);
        drst = 0; #1;

        // Table of scenarios
        for (int r = 0; r < ROWS; r++) begin
            int cyc;
            frame_len = 9'(TBL[r][0]);
            decim = 16'(TBL[r][2]);
            pkt_reset(1, 1);
            exp_len = TBL[r][1];
            exp_gap = TBL[r][2] + 1;
            gap_chk = (TBL[r][4] == 0);
            cyc = 0;
            while (frames_seen < TBL[r][3] && cyc < 5000) begin
                tick();
                core_afull = (TBL[r][4] != 0) && (cyc % TBL[r][4] == TBL[r][4] - 1);
                #1;
                observe();
                cyc++;
            end
            core_afull = 0;
            chk(frames_seen == TBL[r][3], "R5 frames completed in row", 256'(frames_seen), 256'(TBL[r][3]));
        end

        // R7: one enable alone starts nothing
        pkt_reset(1, 0);
        nv = 0;
        for (int i = 0; i < 12; i++) begin tick(); #1; if (tx_valid) nv++; end
        chk(nv == 0, "R7 transmit enable alone", 256'(nv), 256'd0);
        pkt_reset(0, 1);
        nv = 0;
        for (int i = 0; i < 12; i++) begin tick(); #1; if (tx_valid) nv++; end
        chk(nv == 0, "R7 packet enable alone", 256'(nv), 256'd0);

        // R7: frame completes after enable drops mid-frame
        frame_len = 9'd8; decim = 16'd5;
        pkt_reset(1, 1);
        exp_len = 8; gap_chk = 0; nv = 0;
        for (int i = 0; i < 60; i++) begin
            tick();
            if (nv >= 2) ten = 0;
            #1;
            observe();
            if (tx_valid) nv++;
        end
        chk(nv == 8, "R7 started frame runs to completion", 256'(nv), 256'd8);

        // R9: abort mid-frame and restart pattern
        frame_len = 9'd10; decim = 16'd0;
        pkt_reset(1, 1);
        exp_len = 10; gap_chk = 0;
        for (int i = 0; i < 5; i++) begin tick(); #1; observe(); end
        tick(); prst = 1; #1;
        chk(!tx_valid, "R9 abort drops valid", 256'(tx_valid), 256'd0);
        tick(); prst = 0;
        model_reset();
        first = 1;
        for (int i = 0; i < 40 && frames_seen < 1; i++) begin
            tick(); #1;
            if (tx_valid && first) begin
                chk(tx_data == {64'd0, 64'd0, 128'd1}, "R9 pattern restarts", tx_data, {64'd0, 64'd0, 128'd1});
                first = 0;
            end
            observe();
        end
        chk(frames_seen == 1, "R9 full frame after abort", 256'(frames_seen), 256'd1);

        // R10: destination latched per frame
        cfg_dst_ip = 32'h0A00_0001; cfg_dst_port = 16'h1234;
        frame_len = 9'd6; decim = 16'd2;
        pkt_reset(1, 1);
        exp_len = 6; gap_chk = 1; exp_gap = 3;
        first = 1;
        for (int i = 0; i < 60 && frames_seen < 2; i++) begin
            tick();
            if (!first) begin cfg_dst_ip = 32'hC0A8_0102; cfg_dst_port = 16'h5678; end
            #1;
            if (tx_valid) begin
                if (frames_seen == 0)
                    chk({tx_dst_ip, tx_dst_port} == {32'h0A00_0001, 16'h1234}, "R10 held during frame",
                        256'({tx_dst_ip, tx_dst_port}), 256'({32'h0A00_0001, 16'h1234}));
                else
                    chk({tx_dst_ip, tx_dst_port} == {32'hC0A8_0102, 16'h5678}, "R10 new frame takes new value",
                        256'({tx_dst_ip, tx_dst_port}), 256'({32'hC0A8_0102, 16'h5678}));
                first = 0;
            end
            observe();
        end
        chk(frames_seen == 2, "R10 two frames seen", 256'(frames_seen), 256'd2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule